// File: doc/BRIEF.md
# Switch Port-Group Forwarding Resolver

This block works out the egress port mask for one frame in a small layer-2 switch. A single table of port-group masks is read three times for every lookup request. The first read uses a destination index: the MAC-table index on a hit, or a per-class flood index on a miss. The second read uses an aggregation index taken from the frame's 4-bit link aggregation code. The third read uses a source index taken from the ingress port. The three masks are ANDed together and the ingress port's own bit is then cleared. The first read carries the forwarding group, the second keeps one member of each aggregated link, and the third enforces the port-to-port forwarding matrix.

The result is registered and comes out with a valid strobe a fixed two cycles after the request. A new request can be accepted in every cycle. A simple register-style port gives software read and write access to every table entry and to the five flood-index registers. The mask width is the number of physical ports plus one. The top bit stands for the CPU port.

Top module: `pgrp_fwd_resolver`

## Requirements
- R1: After reset, `out_valid` is 0. Table entry g reads as follows: for g < NPORT, only bit g set. Entry 58 has only bit NPORT (CPU) set. Entries 59 to 63 and all entries from 64 up are all ones over bits 0..NPORT. Every other entry is zero. The flood-index registers for class codes 0..4 read 59, 60, 61, 62, 63.
- R2: When `req_hit` is 1, the destination entry index is `req_dst`.
- R3: When `req_hit` is 0, the destination index comes from the flood register of `req_cls`. The class codes are 0 unknown unicast, 1 non-IP multicast, 2 IPv4 multicast, 3 IPv6 multicast, 4 broadcast. Class codes 5..7 resolve to index 57.
- R4: The aggregation entry index is 64 + `req_lac`.
- R5: The source entry index is 80 + `req_port`. The result is the bitwise AND of the destination, aggregation and source masks.
- R6: Bit `req_port` of the result is always 0.
- R7: Entry 57 always reads as zero and ignores writes. A lookup that resolves to it still returns `out_valid` = 1, with an all-zero mask.
- R8: A request in cycle t produces `out_valid` in cycle t+2. Back-to-back requests produce back-to-back results.
- R9: A table write in the same cycle as a lookup request that reads the same entry does not affect that lookup. The write is seen by later lookups.
- R10: Configuration addresses 0..(80+NPORT-1) select table entries. Addresses 96..100 select the flood registers for class codes 0..4, using the low 6 data bits. A read returns data on `cfg_rdata` in the cycle after `cfg_re`. Unmapped addresses read 0 and ignore writes.
- R11: Bit NPORT (the CPU port) takes part in the AND like any physical port bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_port | input | 4 | Ingress physical port number |
| req_hit | input | 1 | MAC table hit |
| req_dst | input | 6 | Destination index from MAC table |
| req_cls | input | 3 | Traffic class code for flooding |
| req_lac | input | 4 | Link aggregation code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | 7 | Configuration address |
| cfg_wdata | input | 12 | Configuration write data |
| cfg_rdata | output | 12 | Configuration read data, registered |
| out_valid | output | 1 | Result strobe |
| out_mask | output | 12 | Egress port mask, bit 11 is the CPU port |

## Verification
The assertions assume that `req_port` is always a physical port below NPORT. The self-exclusion and source-subset properties index the mask with it. The stimulus only draws ports 0 to 10. The properties also assume that no request is in flight across reset; the bench holds `req_valid` low until reset is released. Flood registers are only ever written with destination indices below 64, so every miss lands inside the destination range.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
    // Traffic class codes used when the MAC lookup misses
    typedef enum logic [2:0] {
        CLS_UUC = 3'd0,
        CLS_MC  = 3'd1,
        CLS_IP4 = 3'd2,
        CLS_IP6 = 3'd3,
        CLS_BC  = 3'd4
    } fld_cls_e;

    localparam int NUM_CLS        = 5;
    localparam int DST_ENTRIES    = 64;
    localparam int AGG_BASE       = 64;
    localparam int SRC_BASE       = 80;
    localparam int IDX_DROP       = 57;
    localparam int IDX_CPUWL      = 58;
    localparam int IDX_FLOOD_LO   = 59;
    localparam int CFG_FLOOD_BASE = 96;
    localparam int FIW            = $clog2(DST_ENTRIES);
endpackage

// File: rtl/pgr_mask_table.sv
module pgr_mask_table
    import pgr_pkg::*;
#(
    parameter int NPORT = 11,
    parameter int MW    = NPORT + 1,
    parameter int CAW   = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CAW-1:0] wr_idx,
    input  logic [MW-1:0]  wr_mask,
    input  logic [CAW-1:0] dst_idx,
    input  logic [CAW-1:0] agg_idx,
    input  logic [CAW-1:0] src_idx,
    input  logic [CAW-1:0] cfg_idx,
    output logic [MW-1:0]  dst_mask,
    output logic [MW-1:0]  agg_mask,
    output logic [MW-1:0]  src_mask,
    output logic [MW-1:0]  cfg_mask
);
    localparam int DEPTH = SRC_BASE + NPORT;
    localparam int TSZ   = 2 ** CAW;

    function automatic logic [MW-1:0] def_mask(int g);
        if (g < NPORT)        return MW'(1) << g;
        if (g == IDX_CPUWL)   return MW'(1) << NPORT;
        if (g >= IDX_FLOOD_LO) return '1;
        return '0;
    endfunction

    logic [MW-1:0] ent_w [TSZ];

    for (genvar g = 0; g < TSZ; g++) begin : g_ent
        if (g == IDX_DROP || g >= DEPTH) begin : g_const
            assign ent_w[g] = '0;
        end else begin : g_reg
            logic [MW-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= def_mask(g);
                else if (wr_en && wr_idx == CAW'(g))
                    q <= wr_mask;
            end
            assign ent_w[g] = q;
        end
    end

    assign dst_mask = ent_w[dst_idx];
    assign agg_mask = ent_w[agg_idx];
    assign src_mask = ent_w[src_idx];
    assign cfg_mask = ent_w[cfg_idx];
endmodule

// File: rtl/pgr_dst_select.sv
module pgr_dst_select
    import pgr_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [FIW-1:0] wr_idx,
    input  logic [2:0]     rd_sel,
    output logic [FIW-1:0] rd_idx,
    input  logic           hit,
    input  logic [FIW-1:0] mac_idx,
    input  logic [2:0]     cls,
    output logic [FIW-1:0] dst_idx
);
    logic [FIW-1:0] fl_w [8];

    for (genvar c = 0; c < 8; c++) begin : g_cls
        if (c >= NUM_CLS) begin : g_undef
            assign fl_w[c] = FIW'(IDX_DROP);
        end else begin : g_reg
            logic [FIW-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= FIW'(IDX_FLOOD_LO + c);
                else if (wr_en && wr_sel == 3'(c))
                    q <= wr_idx;
            end
            assign fl_w[c] = q;
        end
    end

    assign rd_idx  = fl_w[rd_sel];
    assign dst_idx = hit ? mac_idx : fl_w[cls];
endmodule

// File: rtl/pgr_combine.sv
module pgr_combine #(
    parameter int NPORT = 11,
    parameter int MW    = NPORT + 1,
    parameter int PW    = $clog2(NPORT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s1_valid,
    input  logic [PW-1:0] s1_port,
    input  logic [MW-1:0] s1_dst,
    input  logic [MW-1:0] s1_agg,
    input  logic [MW-1:0] s1_src,
    output logic          out_valid,
    output logic [MW-1:0] out_mask
);
    logic [MW-1:0] self_bit;
    assign self_bit = MW'(1) << s1_port;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_mask <= s1_dst & s1_agg & s1_src & ~self_bit;
        end
    end

    // R8
    lat_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    // R8
    idle_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    // R6
    no_self_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> (out_mask[$past(s1_port)] == 1'b0));
    // R5
    src_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> ((out_mask & ~$past(s1_src)) == '0));
endmodule

// File: rtl/pgrp_fwd_resolver.sv
module pgrp_fwd_resolver
    import pgr_pkg::*;
#(
    parameter int NPORT = 11,
    parameter int MW    = NPORT + 1,
    parameter int PW    = $clog2(NPORT),
    parameter int CAW   = $clog2(CFG_FLOOD_BASE + NUM_CLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [PW-1:0]  req_port,
    input  logic           req_hit,
    input  logic [5:0]     req_dst,
    input  logic [2:0]     req_cls,
    input  logic [3:0]     req_lac,
    input  logic           cfg_we,
    input  logic           cfg_re,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [MW-1:0]  cfg_wdata,
    output logic [MW-1:0]  cfg_rdata,
    output logic           out_valid,
    output logic [MW-1:0]  out_mask
);
    // Lookup index generation
    logic [FIW-1:0] sel_dst;
    logic [CAW-1:0] dst_idx, agg_idx, src_idx;

    // Configuration decode
    logic           flood_hit;
    logic [2:0]     fsel;
    logic [FIW-1:0] fl_rd;

    assign flood_hit = (cfg_addr >= CAW'(CFG_FLOOD_BASE)) &&
                       (cfg_addr <  CAW'(CFG_FLOOD_BASE + NUM_CLS));
    assign fsel      = 3'(cfg_addr - CAW'(CFG_FLOOD_BASE));

    pgr_dst_select u_dsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && flood_hit),
        .wr_sel  (fsel),
        .wr_idx  (cfg_wdata[FIW-1:0]),
        .rd_sel  (fsel),
        .rd_idx  (fl_rd),
        .hit     (req_hit),
        .mac_idx (req_dst),
        .cls     (req_cls),
        .dst_idx (sel_dst)
    );

    assign dst_idx = CAW'(sel_dst);
    assign agg_idx = CAW'(AGG_BASE) + CAW'(req_lac);
    assign src_idx = CAW'(SRC_BASE) + CAW'(req_port);

    logic [MW-1:0] rd_dst, rd_agg, rd_src, rd_cfg;

    pgr_mask_table #(.NPORT(NPORT), .MW(MW), .CAW(CAW)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_addr),
        .wr_mask  (cfg_wdata),
        .dst_idx  (dst_idx),
        .agg_idx  (agg_idx),
        .src_idx  (src_idx),
        .cfg_idx  (cfg_addr),
        .dst_mask (rd_dst),
        .agg_mask (rd_agg),
        .src_mask (rd_src),
        .cfg_mask (rd_cfg)
    );

    // Stage 1: masks captured in the request cycle, before any same-edge write lands
    logic          s1_valid;
    logic [PW-1:0] s1_port;
    logic [MW-1:0] s1_dst, s1_agg, s1_src;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_port  <= '0;
            s1_dst   <= '0;
            s1_agg   <= '0;
            s1_src   <= '0;
        end else begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_port <= req_port;
                s1_dst  <= rd_dst;
                s1_agg  <= rd_agg;
                s1_src  <= rd_src;
            end
        end
    end

    pgr_combine #(.NPORT(NPORT), .MW(MW), .PW(PW)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_port   (s1_port),
        .s1_dst    (s1_dst),
        .s1_agg    (s1_agg),
        .s1_src    (s1_src),
        .out_valid (out_valid),
        .out_mask  (out_mask)
    );

    // Configuration read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_rdata <= '0;
        else if (cfg_re)
            cfg_rdata <= flood_hit ? MW'(fl_rd) : rd_cfg;
    end

    // R8
    lat_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> s1_valid);
    // R7
    drop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dst_idx == CAW'(IDX_DROP)) |=> (s1_dst == '0));
    // R4
    agg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (agg_idx >= CAW'(AGG_BASE) && agg_idx < CAW'(SRC_BASE)));
endmodule

// File: tb/pgrp_fwd_resolver_bench.sv
module pgrp_fwd_resolver_bench;
    localparam int NP = 11;
    localparam int MW = NP + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_port = '0;
    logic        req_hit = 1'b0;
    logic [5:0]  req_dst = '0;
    logic [2:0]  req_cls = '0;
    logic [3:0]  req_lac = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        out_valid;
    logic [11:0] out_mask;

    always #2 clk = ~clk;

    pgrp_fwd_resolver u_pgrp_fwd_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_hit(req_hit), .req_dst(req_dst), .req_cls(req_cls), .req_lac(req_lac),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_mask(out_mask)
    );

    int checks = 0;
    int errors = 0;

    logic [11:0] ref_tab [0:90];
    logic [5:0]  ref_fl  [0:4];

    // stream buffers
    int          sq_port [0:199];
    logic        sq_hit  [0:199];
    int          sq_dst  [0:199];
    int          sq_cls  [0:199];
    int          sq_lac  [0:199];
    logic [11:0] sq_exp  [0:199];
    string       sq_tag  [0:199];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_mask(int p, logic hit, int dst, int cls, int lac);
        int d;
        logic [11:0] m;
        if (hit) d = dst;
        else if (cls < 5) d = int'(ref_fl[cls]);
        else d = 57;
        m = (d == 57) ? 12'h000 : ref_tab[d];
        m = m & ref_tab[64 + lac] & ref_tab[80 + p];
        m[p] = 1'b0;
        return m;
    endfunction

    task automatic cfg_write(input int addr, input logic [11:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 91 && addr != 57) ref_tab[addr] = data;
        if (addr >= 96 && addr <= 100) ref_fl[addr - 96] = data[5:0];
    endtask

    task automatic cfg_read(input int addr, input logic [11:0] exp, input string tag);
        @(negedge clk);
        cfg_re = 1'b1; cfg_addr = 7'(addr);
        @(negedge clk);
        cfg_re = 1'b0;
        check(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic run_stream(input int n);
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check({sq_tag[i-2], " valid"}, 32'(out_valid), 32'd1);
                check(sq_tag[i-2], 32'(out_mask), 32'(sq_exp[i-2]));
            end
            if (i < n) begin
                req_valid = 1'b1;
                req_port  = 4'(sq_port[i]);
                req_hit   = sq_hit[i];
                req_dst   = 6'(sq_dst[i]);
                req_cls   = 3'(sq_cls[i]);
                req_lac   = 4'(sq_lac[i]);
            end else begin
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R8 idle after stream", 32'(out_valid), 32'd0);
    endtask

    task automatic push(input int k, input int p, input logic hit, input int dst,
                        input int cls, input int lac, input string tag);
        sq_port[k] = p; sq_hit[k] = hit; sq_dst[k] = dst;
        sq_cls[k] = cls; sq_lac[k] = lac; sq_tag[k] = tag;
        sq_exp[k] = exp_mask(p, hit, dst, cls, lac);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        // reference defaults (R1)
        for (int g = 0; g < 91; g++) begin
            if (g < NP) ref_tab[g] = 12'(1) << g;
            else if (g == 58) ref_tab[g] = 12'h800;
            else if (g >= 59) ref_tab[g] = 12'hFFF;
            else ref_tab[g] = 12'h000;
        end
        for (int c = 0; c < 5; c++) ref_fl[c] = 6'(59 + c);

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);

        // R1: full readback of reset contents
        for (int g = 0; g < 91; g++) cfg_read(g, ref_tab[g], "R1 table reset");
        for (int c = 0; c < 5; c++) cfg_read(96 + c, 12'(59 + c), "R1 flood reset");

        // R10: program table arithmetically
        for (int g = NP; g < 57; g++) cfg_write(g, 12'((g * 37 + 5) & 12'hFFF));
        for (int c = 0; c < 16; c++)
            cfg_write(64 + c, 12'hFFF & ~((c % 2 == 1) ? 12'h004 : 12'h008));
        for (int i = 0; i < NP; i++)
            cfg_write(80 + i, 12'hFFF & ~(12'(1) << ((i + 3) % NP)));
        cfg_write(57, 12'hFFF);
        cfg_write(92, 12'hABC);
        cfg_write(120, 12'h0FF);
        cfg_read(57, 12'h000, "R7 drop entry ignores write");
        cfg_read(92, 12'h000, "R10 unmapped read");
        cfg_read(120, 12'h000, "R10 unmapped high read");
        cfg_read(20, ref_tab[20], "R10 table readback");
        cfg_read(70, ref_tab[70], "R10 aggregation readback");

        // R2 R4 R5 R6 R11: hit sweep over every port and code
        k = 0;
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < 16; c++) begin
                push(k, p, 1'b1, (p * 7 + c * 5) % 64, 0, c, "R2 R4 R5 hit sweep");
                k++;
            end
        run_stream(k);

        // R3 R7: miss sweep over all class codes
        k = 0;
        for (int cl = 0; cl < 8; cl++)
            for (int p = 0; p < NP; p++) begin
                push(k, p, 1'b0, 0, cl, p, "R3 miss sweep");
                k++;
            end
        run_stream(k);

        // R3 R10: reprogram flood registers
        cfg_write(96, 12'd30);
        cfg_write(100, 12'd5);
        cfg_write(97, 12'd58);
        cfg_read(96, 12'd30, "R10 flood readback");
        cfg_read(100, 12'd5, "R10 flood readback bc");
        k = 0;
        for (int cl = 0; cl < 5; cl++)
            for (int p = 0; p < NP; p++) begin
                push(k, p, 1'b0, 0, cl, (p + cl) % 16, "R3 reprogrammed flood");
                k++;
            end
        run_stream(k);

        // R11: CPU bit only entry via hit
        k = 0;
        push(k, 4, 1'b1, 58, 0, 0, "R11 cpu bit"); k++;
        run_stream(k);
        check("R11 cpu bit value", 32'(sq_exp[0]), 32'h800);

        // R9: write colliding with lookup
        @(negedge clk);
        req_valid = 1'b1; req_port = 4'd0; req_hit = 1'b1; req_dst = 6'd20; req_lac = 4'd0;
        cfg_we = 1'b1; cfg_addr = 7'd20; cfg_wdata = 12'h0F0;
        sq_exp[0] = exp_mask(0, 1'b1, 20, 0, 0);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        ref_tab[20] = 12'h0F0;
        @(negedge clk);
        check("R9 lookup sees old entry", 32'(out_mask), 32'(sq_exp[0]));
        check("R9 valid", 32'(out_valid), 32'd1);
        k = 0;
        push(k, 0, 1'b1, 20, 0, 0, "R9 later lookup sees new entry"); k++;
        run_stream(k);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule